// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a small 32-bit processor that completes one instruction per clock cycle. It fetches a word from a local instruction array at the program counter and decodes it in one of three fixed layouts: register, immediate or jump. It then runs the operation through an adder/subtractor. The result goes back to a 32-entry register file, a store goes to a local data array, and the program counter moves on.

The instruction set is deliberately narrow: register add and subtract, add-immediate, load word, store word and an unconditional jump. Every other encoding is executed as a no-op that only advances the program counter. Instruction memory is filled through a write port, normally while reset is held. Results are observed through a combinational debug port that reads any register.

Top module: `sc32_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0. Each instruction other than a jump advances the program counter by 4. The program counter is always word aligned.
- R2: Opcode bits [31:26] equal to 0 select the register layout, with rs[25:21], rt[20:16], rd[15:11] and function[5:0]. Function code 32 writes rs + rt into rd (for example, 0x02328020 writes r17 + r18 into r16).
- R3: In the register layout, function code 34 writes rs − rt into rd (for example, 0x016D4022 writes r11 − r13 into r8).
- R4: Opcode 8 writes rs plus the sign-extended 16-bit immediate[15:0] into rt, over the full range −32768 to 32767.
- R5: Opcode 35 loads rt from the data word at rs plus the sign-extended offset. Data words are indexed by address bits [9:2] (for example, 0x8E93FFE8 loads r19 from r20 − 24).
- R6: Opcode 43 stores the value of rt to the data word at rs plus the sign-extended offset, and writes no register.
- R7: Opcode 2 sets the program counter to {old PC[31:28], instruction[25:0], 2'b00}.
- R8: Register 0 always reads as zero, both in the datapath and on the debug port. Writes to it are discarded.
- R9: An unrecognised opcode, or a register-layout instruction with a function code other than 32 or 34, changes no register and no data word. It only advances the program counter by 4.
- R10: Register and data writes commit on the rising clock edge. Register reads, including the debug read port, are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the program counter |
| imem_we | input | 1 | Write strobe for the instruction array |
| imem_addr | input | 32 | Byte address of the instruction word to write; bits [9:2] select the word |
| imem_wdata | input | 32 | Instruction word to write |
| dbg_raddr | input | 5 | Register number read by the debug port |
| dbg_rdata | output | 32 | Current value of the register selected by dbg_raddr |
| pc_o | output | 32 | Current program counter |

## Verification
Several rules are checked by the assertions on every cycle. The program counter steps by 4 after every non-jump instruction, and a jump lands on the target assembled from the old upper bits and the index field. The debug port never shows a nonzero register 0. A store never writes a register, and an unrecognised encoding raises neither the register write nor the data write. The arithmetic results, sign extension at both ends of the immediate range, and the store-then-load round trip at a negative offset only show up as register contents after a program has run. The same holds for a discarded write to register 0 and a skipped instruction after a jump, so the bench scenarios cover those.

// File: rtl/sc32_pkg.sv
package sc32_pkg;
   localparam int unsigned INSN_W = 32;

   localparam logic [5:0] OPC_REG    = 6'd0;
   localparam logic [5:0] OPC_JUMP   = 6'd2;
   localparam logic [5:0] OPC_ADDI   = 6'd8;
   localparam logic [5:0] OPC_LOADW  = 6'd35;
   localparam logic [5:0] OPC_STOREW = 6'd43;

   localparam logic [5:0] FN_ADD = 6'd32;
   localparam logic [5:0] FN_SUB = 6'd34;

   typedef enum logic [2:0] {
      K_NOP, K_ADD, K_SUB, K_ADDI, K_LOAD, K_STORE, K_JUMP
   } kind_e;

   typedef struct packed {
      kind_e       kind;
      logic [4:0]  rs;
      logic [4:0]  rt;
      logic [4:0]  rd;
      logic [15:0] imm;
      logic [25:0] target;
   } dec_t;
endpackage

// File: rtl/sc32_decoder.sv
module sc32_decoder
   import sc32_pkg::*;
(
   input  logic [INSN_W-1:0] instr,
   output dec_t              dec
);
   logic [5:0] opc;
   logic [5:0] fn;
   logic       unused_shamt;

   assign opc          = instr[31:26];
   assign fn           = instr[5:0];
   assign unused_shamt = ^instr[10:6];

   always_comb begin
      dec.rs     = instr[25:21];
      dec.rt     = instr[20:16];
      dec.rd     = instr[15:11];
      dec.imm    = instr[15:0];
      dec.target = instr[25:0];
      unique case (opc)
         OPC_REG: begin
            if (fn == FN_ADD)      dec.kind = K_ADD;
            else if (fn == FN_SUB) dec.kind = K_SUB;
            else                   dec.kind = K_NOP;
         end
         OPC_JUMP:   dec.kind = K_JUMP;
         OPC_ADDI:   dec.kind = K_ADDI;
         OPC_LOADW:  dec.kind = K_LOAD;
         OPC_STOREW: dec.kind = K_STORE;
         default:    dec.kind = K_NOP;
      endcase
   end
endmodule

// File: rtl/sc32_addsub.sv
module sc32_addsub #(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] y
);
   logic [W-1:0] b_eff;
   logic [W:0]   sum;
   logic         unused_carry;

   assign b_eff        = sub ? ~b : b;
   assign sum          = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
   assign y            = sum[W-1:0];
   assign unused_carry = sum[W];
endmodule

// File: rtl/sc32_regfile.sv
module sc32_regfile #(
   parameter int unsigned W       = 32,
   parameter int unsigned NREG    = 32,
   parameter bit          ZERO_R0 = 1'b1,
   localparam int unsigned AW     = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] ra_addr,
   output logic [W-1:0]  ra_data,
   input  logic [AW-1:0] rb_addr,
   output logic [W-1:0]  rb_data,
   input  logic [AW-1:0] rc_addr,
   output logic [W-1:0]  rc_data
);
   logic [W-1:0] q [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_ent
      if (i == 0 && ZERO_R0) begin : g_zero
         assign q[i] = '0;
      end else begin : g_reg
         logic [W-1:0] r;
         always_ff @(posedge clk) begin
            if (we && waddr == AW'(i)) r <= wdata;
         end
         assign q[i] = r;
      end
   end

   assign ra_data = q[ra_addr];
   assign rb_data = q[rb_addr];
   assign rc_data = q[rc_addr];
endmodule

// File: rtl/sc32_wordmem.sv
module sc32_wordmem #(
   parameter int unsigned W     = 32,
   parameter int unsigned DEPTH = 256,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/sc32_core.sv
module sc32_core
   import sc32_pkg::*;
#(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned NREG       = 32,
   parameter int unsigned IMEM_DEPTH = 256,
   parameter int unsigned DMEM_DEPTH = 256,
   localparam int unsigned RAW       = $clog2(NREG),
   localparam int unsigned IAW       = $clog2(IMEM_DEPTH),
   localparam int unsigned DAW       = $clog2(DMEM_DEPTH)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            imem_we,
   input  logic [XLEN-1:0] imem_addr,
   input  logic [XLEN-1:0] imem_wdata,
   input  logic [RAW-1:0]  dbg_raddr,
   output logic [XLEN-1:0] dbg_rdata,
   output logic [XLEN-1:0] pc_o
);
   if (XLEN != INSN_W) begin : g_bad_xlen
      $error("sc32_core: XLEN must be 32");
   end
   if (NREG != 32) begin : g_bad_nreg
      $error("sc32_core: register fields are 5 bits, NREG must be 32");
   end
   if ((1 << IAW) != IMEM_DEPTH || (1 << DAW) != DMEM_DEPTH) begin : g_bad_depth
      $error("sc32_core: memory depths must be powers of two");
   end
   if (IAW + 2 > 28 || DAW + 2 > XLEN) begin : g_bad_span
      $error("sc32_core: instruction array must fit below the jump region bits");
   end

   logic [XLEN-1:0] pc_q;
   logic [XLEN-1:0] pc_next;
   logic [XLEN-1:0] instr;
   dec_t            dec;
   logic [XLEN-1:0] rs_val;
   logic [XLEN-1:0] rt_val;
   logic [XLEN-1:0] imm_sx;
   logic [XLEN-1:0] alu_b;
   logic [XLEN-1:0] alu_y;
   logic            alu_sub;
   logic            rf_we;
   logic [RAW-1:0]  rf_waddr;
   logic [XLEN-1:0] rf_wdata;
   logic            dm_we;
   logic [XLEN-1:0] dm_rdata;
   logic            use_imm;
   logic            unused_bits;

   always_ff @(posedge clk) begin
      if (rst) pc_q <= '0;
      else     pc_q <= pc_next;
   end
   assign pc_o = pc_q;

   sc32_wordmem #(.W(XLEN), .DEPTH(IMEM_DEPTH)) u_imem (
      .clk   (clk),
      .we    (imem_we),
      .waddr (imem_addr[IAW+1:2]),
      .wdata (imem_wdata),
      .raddr (pc_q[IAW+1:2]),
      .rdata (instr)
   );

   sc32_decoder u_dec (
      .instr (instr),
      .dec   (dec)
   );

   always_comb begin
      rf_we    = 1'b0;
      dm_we    = 1'b0;
      use_imm  = 1'b0;
      alu_sub  = 1'b0;
      rf_waddr = dec.rt;
      unique case (dec.kind)
         K_ADD:   begin rf_we = 1'b1; rf_waddr = dec.rd; end
         K_SUB:   begin rf_we = 1'b1; rf_waddr = dec.rd; alu_sub = 1'b1; end
         K_ADDI:  begin rf_we = 1'b1; use_imm = 1'b1; end
         K_LOAD:  begin rf_we = 1'b1; use_imm = 1'b1; end
         K_STORE: begin dm_we = 1'b1; use_imm = 1'b1; end
         default: ;
      endcase
   end

   sc32_regfile #(.W(XLEN), .NREG(NREG), .ZERO_R0(1'b1)) u_rf (
      .clk     (clk),
      .we      (rf_we & ~rst),
      .waddr   (rf_waddr),
      .wdata   (rf_wdata),
      .ra_addr (dec.rs),
      .ra_data (rs_val),
      .rb_addr (dec.rt),
      .rb_data (rt_val),
      .rc_addr (dbg_raddr),
      .rc_data (dbg_rdata)
   );

   assign imm_sx = {{(XLEN-16){dec.imm[15]}}, dec.imm};
   assign alu_b  = use_imm ? imm_sx : rt_val;

   sc32_addsub #(.W(XLEN)) u_alu (
      .a   (rs_val),
      .b   (alu_b),
      .sub (alu_sub),
      .y   (alu_y)
   );

   sc32_wordmem #(.W(XLEN), .DEPTH(DMEM_DEPTH)) u_dmem (
      .clk   (clk),
      .we    (dm_we & ~rst),
      .waddr (alu_y[DAW+1:2]),
      .wdata (rt_val),
      .raddr (alu_y[DAW+1:2]),
      .rdata (dm_rdata)
   );

   assign rf_wdata = (dec.kind == K_LOAD) ? dm_rdata : alu_y;

   always_comb begin
      if (dec.kind == K_JUMP) pc_next = {pc_q[XLEN-1:XLEN-4], dec.target, 2'b00};
      else                    pc_next = pc_q + XLEN'(4);
   end

   assign unused_bits = ^{imem_addr[XLEN-1:IAW+2], imem_addr[1:0],
                          alu_y[XLEN-1:DAW+2], alu_y[1:0],
                          pc_q[XLEN-5:IAW+2], pc_q[1:0]};
endmodule

// File: rtl/sc32_checker.sv
module sc32_checker (
   input logic        clk,
   input logic        rst,
   input logic [31:0] pc_o,
   input logic [31:0] instr,
   input logic [4:0]  dbg_raddr,
   input logic [31:0] dbg_rdata,
   input logic        rf_we,
   input logic        dm_we
);
   logic [5:0] opc;
   logic       known_op;
   assign opc      = instr[31:26];
   assign known_op = (opc == 6'd2) || (opc == 6'd8) || (opc == 6'd35) || (opc == 6'd43) ||
                     (opc == 6'd0 && (instr[5:0] == 6'd32 || instr[5:0] == 6'd34));

   assert_pc_step_R1: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(opc) != 6'd2) |-> pc_o == $past(pc_o) + 32'd4);

   assert_pc_aligned_R1: assert property (@(posedge clk) disable iff (rst)
      pc_o[1:0] == 2'b00);

   assert_jump_target_R7: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(opc) == 6'd2) |->
      pc_o == {$past(pc_o[31:28]), $past(instr[25:0]), 2'b00});

   assert_zero_reg_R8: assert property (@(posedge clk) disable iff (rst)
      dbg_raddr == 5'd0 |-> dbg_rdata == 32'd0);

   assert_store_no_rf_R6: assert property (@(posedge clk) disable iff (rst)
      dm_we |-> (!rf_we && opc == 6'd43));

   assert_unknown_quiet_R9: assert property (@(posedge clk) disable iff (rst)
      !known_op |-> (!rf_we && !dm_we));
endmodule

bind sc32_core sc32_checker u_chk (
   .clk       (clk),
   .rst       (rst),
   .pc_o      (pc_o),
   .instr     (instr),
   .dbg_raddr (dbg_raddr),
   .dbg_rdata (dbg_rdata),
   .rf_we     (rf_we),
   .dm_we     (dm_we)
);

// File: tb/sim_sc32_core.sv
module sim_sc32_core;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        imem_we = 1'b0;
   logic [31:0] imem_addr = '0;
   logic [31:0] imem_wdata = '0;
   logic [4:0]  dbg_raddr = '0;
   logic [31:0] dbg_rdata;
   logic [31:0] pc_o;

   int errors = 0;
   int checks = 0;
   bit run_done = 0;
   bit mon_done = 0;

   typedef struct {
      string       tag;
      logic [4:0]  idx;
      logic [31:0] val;
   } exp_t;
   exp_t sb[$];

   always #5 clk = ~clk;

   sc32_core u0 (
      .clk (clk), .rst (rst),
      .imem_we (imem_we), .imem_addr (imem_addr), .imem_wdata (imem_wdata),
      .dbg_raddr (dbg_raddr), .dbg_rdata (dbg_rdata), .pc_o (pc_o)
   );

   function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
      return {6'd0, rs, rt, rd, 5'd0, fn};
   endfunction
   function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction
   function automatic logic [31:0] enc_j(logic [25:0] tgt);
      return {6'd2, tgt};
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic load_word(int idx, logic [31:0] w);
      @(negedge clk);
      imem_we = 1'b1; imem_addr = 32'(idx * 4); imem_wdata = w;
      @(negedge clk);
      imem_we = 1'b0;
   endtask

   // driver side of the scoreboard
   task automatic expect_reg(string tag, logic [4:0] idx, logic [31:0] val);
      exp_t e;
      e.tag = tag; e.idx = idx; e.val = val;
      sb.push_back(e);
   endtask

   // monitor: pops expected items and compares them to the debug port
   initial begin
      wait (run_done);
      while (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         @(negedge clk);
         dbg_raddr = e.idx;
         #1;
         check(e.tag, dbg_rdata, e.val);
      end
      mon_done = 1;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst = 1'b1;
      load_word(0,  enc_i(6'd8, 5'd0, 5'd17, 16'd100));        // R4
      load_word(1,  enc_i(6'd8, 5'd0, 5'd18, 16'hFFF9));       // R4 negative
      load_word(2,  32'h02328020);                              // R2 add r16
      load_word(3,  enc_i(6'd8, 5'd0, 5'd11, 16'd50));
      load_word(4,  enc_i(6'd8, 5'd0, 5'd13, 16'd80));
      load_word(5,  32'h016D4022);                              // R3 sub r8
      load_word(6,  enc_i(6'd8, 5'd0, 5'd20, 16'd64));
      load_word(7,  enc_i(6'd8, 5'd0, 5'd5, 16'h1234));
      load_word(8,  enc_i(6'd43, 5'd20, 5'd5, 16'hFFE8));      // R6 sw r5,-24(r20)
      load_word(9,  32'h8E93FFE8);                              // R5 lw r19
      load_word(10, enc_i(6'd8, 5'd0, 5'd0, 16'd55));          // R8 write r0
      load_word(11, enc_r(5'd0, 5'd17, 5'd9, 6'd32));          // R8 r0 in datapath
      load_word(12, {6'd63, 5'd0, 5'd9, 16'd7});               // R9 bad opcode
      load_word(13, enc_r(5'd17, 5'd18, 5'd9, 6'd36));         // R9 bad function
      load_word(14, enc_j(26'd20));                             // R7
      load_word(15, enc_i(6'd8, 5'd0, 5'd9, 16'd1));           // skipped
      load_word(20, enc_i(6'd8, 5'd20, 5'd10, 16'h7FFF));      // R4 max
      load_word(21, enc_i(6'd8, 5'd0, 5'd12, 16'h8000));       // R4 min
      load_word(22, enc_i(6'd43, 5'd0, 5'd12, 16'd0));         // R6
      load_word(23, enc_i(6'd35, 5'd0, 5'd14, 16'd0));         // R5
      load_word(24, enc_j(26'd24));                             // R7 self loop
      @(negedge clk);
      check("R1 reset pc", pc_o, 32'd0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 pc+4", pc_o, 32'd4);
      repeat (14) @(negedge clk);
      check("R7 jump target", pc_o, 32'd80);
      repeat (20) @(negedge clk);
      check("R7 self jump", pc_o, 32'd96);
      @(negedge clk);
      check("R7 self jump stays", pc_o, 32'd96);

      expect_reg("R2 add r16", 5'd16, 32'd93);
      expect_reg("R3 sub r8", 5'd8, 32'hFFFFFFE2);
      expect_reg("R4 addi r17", 5'd17, 32'd100);
      expect_reg("R4 addi negative r18", 5'd18, 32'hFFFFFFF9);
      expect_reg("R5 R6 lw after sw r19", 5'd19, 32'h00001234);
      expect_reg("R8 r0 zero", 5'd0, 32'd0);
      expect_reg("R9 r9 unchanged", 5'd9, 32'd100);
      expect_reg("R4 addi max r10", 5'd10, 32'd32831);
      expect_reg("R4 addi min r12", 5'd12, 32'hFFFF8000);
      expect_reg("R5 lw r14", 5'd14, 32'hFFFF8000);
      expect_reg("R10 r20 base", 5'd20, 32'd64);
      run_done = 1;
      wait (mon_done);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule